// File: doc/BRIEF.md
# Multiplexed GPIO Port Bank

A bank of 32 pins behind a simple synchronous register port. Each pin belongs either to the bank's own GPIO logic or to one of two peripheral functions, called A and B. Every per-pin attribute is held in a state word: pin ownership, peripheral-B select, output enable, output data, pull-up, open-drain (multi-drive) and input glitch filter. Software changes an attribute only by writing a mask to that attribute's set word or to its clear word. A 1 in the mask acts on that pin and a 0 leaves it alone, so no read-modify-write is needed. Each attribute also has a readable status word.

The pad side uses three separate vectors: pin level in, drive value out and drive enable out. There is also a pull-up enable vector. For a pin in open-drain mode, the driver only pulls the pin low and releases it for a 1. Pin levels pass through a two-flop synchronizer and an optional per-pin glitch filter before they reach a readable pin-level word. That word reports every pin whatever its mux setting.

Writes take effect at the clock edge on which `bus_wr` is high. Read data is combinational from `bus_addr`.

Top module: `gpio_mux_bank`

## Requirements
- R1: After reset the status words read as follows: ownership all ones (every pin GPIO), B-select 0, output enable 0, output data 0, pull-up all ones, multi-drive 0, filter 0. After reset `pad_oe` is 0 and `pad_pu` is all ones.
- R2: Attribute k is numbered ownership 0, B-select 1, output enable 2, output data 3, pull-up 4, multi-drive 5, filter 6. For attribute k, a write to word 3k sets the masked bits, a write to word 3k+1 clears them, and word 3k+2 reads the state. Bits written as 0 leave the state unchanged.
- R3: A pin whose ownership bit is 1 drives its output-data bit under the control of its output-enable bit.
- R4: A pin whose ownership bit is 0 takes its drive value and enable from `per_b_*` when its B-select bit is 1, and from `per_a_*` otherwise. A write to word 4 (clear B-select) picks peripheral A.
- R5: Output data can be loaded while the output is disabled. The preset level then appears on `pad_out` as soon as the enable write completes, with no further cycle.
- R6: For a pin with multi-drive on, `pad_out` is 0 and `pad_oe` is 1 only when the selected source drives 0 with its enable set.
- R7: `pad_pu` follows the pull-up state word bit for bit.
- R8: Word 21 returns the pin levels. With the filter off, a change on `pad_in` shows there after exactly two clock edges, for pins under any owner.
- R9: With the filter on for a pin, a level one clock period wide never reaches word 21. A level that stays stable shows there after exactly four clock edges.
- R10: Words 22 to 31 read 0. A write to them, or to a status word, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, takes effect at the rising edge |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write mask |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Drive value to the pads |
| pad_oe | output | 32 | Drive enable to the pads |
| pad_pu | output | 32 | Pull-up enable to the pads |
| per_a_out | input | 32 | Peripheral A drive value |
| per_a_oe | input | 32 | Peripheral A drive enable |
| per_b_out | input | 32 | Peripheral B drive value |
| per_b_oe | input | 32 | Peripheral B drive enable |

## Verification
The hardest situation to reach is the filter's edge case: a one-period pulse on a filtered pin must never show, while a stable level must show on the fourth edge and not on the third. The bench lines up a pin change with a falling edge and samples word 21 on each later falling edge, so the exact edge count is checked. Random traffic with a fixed seed goes to all 32 addresses, including status and unused words. After each write, the pad vectors and a random status word are compared against a bench model, with new random peripheral inputs every time. This covers every mix of owner, B-select and open-drain.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NATTR   = 7;
  localparam int AT_OWN  = 0;
  localparam int AT_SELB = 1;
  localparam int AT_OE   = 2;
  localparam int AT_DAT  = 3;
  localparam int AT_PU   = 4;
  localparam int AT_MD   = 5;
  localparam int AT_GF   = 6;
  localparam int PINSTAT_WORD = 3 * NATTR;

  // reset value of every bit of attribute k
  function automatic logic attr_rst_bit(int k);
    return (k == AT_OWN) || (k == AT_PU);
  endfunction

  // next state of an attribute word: clear dominates set
  function automatic logic attr_next(logic q, logic s, logic c);
    return (q | s) & ~c;
  endfunction

  // pad drive for one pin: returns {oe, out}
  function automatic logic [1:0] pad_drive(logic d, logic en, logic md);
    if (md) return {en & ~d, 1'b0};
    return {en, d};
  endfunction
endpackage

// File: rtl/gpio_bank_attr.sv
module gpio_bank_attr #(
  parameter int   W   = 32,
  parameter logic RST = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_m,
  input  logic [W-1:0] clr_m,
  output logic [W-1:0] q
);
  import gpio_bank_pkg::*;

  logic [W-1:0] q_nxt;
  always_comb
    for (int i = 0; i < W; i++) q_nxt[i] = attr_next(q[i], set_m[i], clr_m[i]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= {W{RST}};
    else        q <= q_nxt;

  p_set_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & $past(set_m & ~clr_m)) == $past(set_m & ~clr_m)));
  p_clr_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & $past(clr_m)) == '0));
  p_zero_bits_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q ^ $past(q)) & ~$past(set_m | clr_m)) == '0));
endmodule

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 5
) (
  input  logic                        wr,
  input  logic [AW-1:0]               addr,
  input  logic [NPINS-1:0]            wdata,
  input  logic [NATTR-1:0][NPINS-1:0] attr_q,
  input  logic [NPINS-1:0]            pin_stat,
  output logic [NATTR-1:0][NPINS-1:0] set_m,
  output logic [NATTR-1:0][NPINS-1:0] clr_m,
  output logic [NPINS-1:0]            rdata
);
  for (genvar k = 0; k < NATTR; k++) begin : g_strobe
    assign set_m[k] = (wr && int'(addr) == 3 * k)     ? wdata : '0;
    assign clr_m[k] = (wr && int'(addr) == 3 * k + 1) ? wdata : '0;
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NATTR; k++)
      if (int'(addr) == 3 * k + 2) rdata = attr_q[k];
    if (int'(addr) == PINSTAT_WORD) rdata = pin_stat;
  end
endmodule

// File: rtl/gpio_bank_infilt.sv
module gpio_bank_infilt #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] gf_en,
  output logic [NPINS-1:0] pin_stat
);
  logic [NPINS-1:0] sync1, sync2, prev, filt;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sync1[i] <= 1'b0;
        sync2[i] <= 1'b0;
        prev[i]  <= 1'b0;
        filt[i]  <= 1'b0;
      end else begin
        sync1[i] <= pad_in[i];
        sync2[i] <= sync1[i];
        prev[i]  <= sync2[i];
        if (sync2[i] == prev[i]) filt[i] <= sync2[i];
      end
    assign pin_stat[i] = gf_en[i] ? filt[i] : sync2[i];
  end

  // a filtered level may only change to a value seen on two samples in a row
  p_filter_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (((filt ^ $past(filt)) & (filt ^ prev)) == '0));
endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pu,
  input  logic [NPINS-1:0] per_a_out,
  input  logic [NPINS-1:0] per_a_oe,
  input  logic [NPINS-1:0] per_b_out,
  input  logic [NPINS-1:0] per_b_oe
);
  logic [NATTR-1:0][NPINS-1:0] attr_q, set_m, clr_m;
  logic [NPINS-1:0]            pin_stat;

  gpio_bank_decode #(.NPINS(NPINS), .AW(AW)) u_dec (
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .attr_q(attr_q),
    .pin_stat(pin_stat), .set_m(set_m), .clr_m(clr_m), .rdata(bus_rdata));

  for (genvar k = 0; k < NATTR; k++) begin : g_attr
    gpio_bank_attr #(.W(NPINS), .RST(attr_rst_bit(k))) u_reg (
      .clk(clk), .rst_n(rst_n), .set_m(set_m[k]), .clr_m(clr_m[k]), .q(attr_q[k]));
  end

  gpio_bank_infilt #(.NPINS(NPINS)) u_filt (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .gf_en(attr_q[AT_GF]),
    .pin_stat(pin_stat));

  // named per-pin source selection, then drive shaping
  logic [NPINS-1:0] src_d, src_en;
  for (genvar i = 0; i < NPINS; i++) begin : g_pad
    always_comb begin
      if (attr_q[AT_OWN][i])       begin src_d[i] = attr_q[AT_DAT][i]; src_en[i] = attr_q[AT_OE][i]; end
      else if (attr_q[AT_SELB][i]) begin src_d[i] = per_b_out[i];      src_en[i] = per_b_oe[i];      end
      else                         begin src_d[i] = per_a_out[i];      src_en[i] = per_a_oe[i];      end
    end
    assign {pad_oe[i], pad_out[i]} = pad_drive(src_d[i], src_en[i], attr_q[AT_MD][i]);
  end

  assign pad_pu = attr_q[AT_PU];

  p_gpio_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((attr_q[AT_OWN] & ~attr_q[AT_MD] & (pad_oe ^ attr_q[AT_OE])) == '0));
  p_periph_a_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((~attr_q[AT_OWN] & ~attr_q[AT_SELB] & ~attr_q[AT_MD] & (pad_oe ^ per_a_oe)) == '0));
  p_periph_b_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((~attr_q[AT_OWN] & attr_q[AT_SELB] & ~attr_q[AT_MD] & (pad_out ^ per_b_out)) == '0));
  p_open_drain_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((attr_q[AT_MD] & pad_out) == '0));
endmodule

// File: tb/gpio_mux_bank_bench.sv
`timescale 1ns/1ps
module gpio_mux_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pad_in = '0, pad_out, pad_oe, pad_pu;
  logic [31:0] per_a_out = '0, per_a_oe = '0, per_b_out = '0, per_b_oe = '0;

  int errors = 0;
  int checks = 0;
  logic [31:0] m [7];

  always #4 clk = ~clk;

  gpio_mux_bank u_gpio_mux_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .per_a_out(per_a_out), .per_a_oe(per_a_oe),
    .per_b_out(per_b_out), .per_b_oe(per_b_oe));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model_wr(int a, logic [31:0] d);
    if (a < 21 && a % 3 == 0) m[a / 3] = m[a / 3] | d;
    if (a < 21 && a % 3 == 1) m[a / 3] = m[a / 3] & ~d;
  endfunction

  function automatic logic [31:0] model_rd(int a, logic [31:0] pins);
    if (a < 21 && a % 3 == 2) return m[a / 3];
    if (a == 21) return pins;
    return '0;
  endfunction

  // returns {oe, out}
  function automatic logic [63:0] model_pad();
    logic [31:0] o, e;
    for (int i = 0; i < 32; i++) begin
      logic d, en;
      d  = m[0][i] ? m[3][i] : (m[1][i] ? per_b_out[i] : per_a_out[i]);
      en = m[0][i] ? m[2][i] : (m[1][i] ? per_b_oe[i]  : per_a_oe[i]);
      o[i] = m[5][i] ? 1'b0 : d;
      e[i] = m[5][i] ? (en && !d) : en;
    end
    return {e, o};
  endfunction

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd_check(string req, int a, logic [31:0] exp);
    bus_addr = 5'(a);
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pad_check(string req);
    logic [63:0] x;
    #1;
    x = model_pad();
    check({req, " oe"}, pad_oe, x[63:32]);
    check({req, " out"}, pad_out, x[31:0]);
    check({req, " pu"}, pad_pu, m[4]);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    m[0] = '1; m[1] = '0; m[2] = '0; m[3] = '0; m[4] = '1; m[5] = '0; m[6] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int k = 0; k < 7; k++) rd_check("R1 reset status", 3 * k + 2, m[k]);
    pad_check("R1 reset pads");

    // R5 preset data while disabled, then enable
    wr(9, 32'h0000_000F);
    pad_check("R5 preset disabled");
    wr(6, 32'h0000_000F);
    #1;
    check("R5 preset on enable", pad_out & 32'hF, 32'hF);
    check("R5 oe on enable", pad_oe & 32'hF, 32'hF);

    // R2 zero bits leave state alone; clear of one bit
    wr(6, 32'h0);
    wr(10, 32'h0000_0002);
    rd_check("R2 zero mask holds oe", 8, 32'h0000_000F);
    rd_check("R2 clear one data bit", 11, 32'h0000_000D);

    // R6 open drain on pin 0
    wr(15, 32'h0000_0001);
    pad_check("R6 md drive one");
    check("R6 released for 1", pad_oe & 32'h1, 32'h0);
    wr(10, 32'h0000_0001);
    pad_check("R6 md drive zero");
    check("R6 pulls low", pad_oe & 32'h1, 32'h1);

    // R4 peripheral routing
    per_a_out = 32'h0000_0050; per_a_oe = 32'h0000_00F0;
    per_b_out = 32'h0000_0080; per_b_oe = 32'h0000_00C0;
    wr(1, 32'h0000_00F0);
    wr(3, 32'h0000_00C0);
    pad_check("R4 A and B routing");
    wr(4, 32'h0000_0040);
    pad_check("R4 select A back");
    rd_check("R4 selb status", 5, 32'h0000_0080);

    // R7 pull-up
    wr(13, 32'h00FF_0000);
    pad_check("R7 pull-up clear");

    // R8 latency without filter, on a peripheral-owned pin
    @(negedge clk);
    pad_in = 32'h0000_0010;
    bus_addr = 5'd21;
    @(negedge clk); #1 check("R8 one edge old", bus_rdata, 32'h0);
    @(negedge clk); #1 check("R8 two edges new", bus_rdata, 32'h0000_0010);

    // R9 filter on pin 5: pulse rejected, stable accepted on fourth edge
    wr(18, 32'h0000_0020);
    @(negedge clk);
    pad_in = 32'h0000_0030;
    bus_addr = 5'd21;
    @(negedge clk);
    pad_in = 32'h0000_0010;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk); #1 check("R9 pulse rejected", bus_rdata, 32'h0000_0010);
    end
    pad_in = 32'h0000_0030;
    repeat (3) @(negedge clk);
    #1 check("R9 three edges old", bus_rdata, 32'h0000_0010);
    @(negedge clk); #1 check("R9 four edges new", bus_rdata, 32'h0000_0030);

    // R10 unused and status words
    wr(25, 32'hFFFF_FFFF);
    wr(2, 32'h0);
    wr(8, 32'hFFFF_FFFF);
    for (int k = 0; k < 7; k++) rd_check("R10 no state change", 3 * k + 2, m[k]);
    rd_check("R10 unused reads zero", 25, 32'h0);

    // random traffic, R2 R3 R4 R6
    pad_in = 32'hA5C3_1E96;
    repeat (6) @(negedge clk);
    for (int it = 0; it < 400; it++) begin
      int a;
      a = $urandom_range(0, 31);
      wr(a, $urandom);
      per_a_out = $urandom; per_a_oe = $urandom;
      per_b_out = $urandom; per_b_oe = $urandom;
      pad_check("R3 random pads");
      a = $urandom_range(0, 31);
      rd_check("R2 random readback", a, model_rd(a, pad_in));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule